// File: doc/BRIEF.md
# Framebuffer pixel format unpacker

This block sits between a framebuffer word fetcher and a display pipeline. It takes one 32-bit framebuffer word at a time and splits it into a run of pixels. Each pixel leaves as a 24-bit colour, with red in bits 23:16, green in 15:8 and blue in 7:0. The pixel depth is chosen by a 3-bit code. Control bits choose the byte and pixel ordering inside a word and can exchange red with blue. A 2-bit mux select and a variant strap decide how 16-bit pixels are read. Depths of 8 bits and below are palette indices. For those, the block drives the index out and passes through the colour that an external palette returns in the same cycle. The block also reports how many framebuffer bytes one display line of `cols` pixels occupies.

Words arrive on a valid/ready handshake and pixels leave on another. The configuration inputs must stay constant while a word is being drained. The control state machine has two states. In `S_EMPTY` no word is held and `word_ready` is high. In `S_DRAIN` a word is held and pixels are offered. There are three transitions. *load* goes from `S_EMPTY` to `S_DRAIN` when a word is taken. *reload* stays in `S_DRAIN`: the last pixel of the word is taken and a new word is taken in the same cycle. *drain_done* goes from `S_DRAIN` to `S_EMPTY`: the last pixel is taken and no new word arrives.

Top module: `fb_unpack`

## Requirements
- R1: `depth_code` selects the bits per pixel: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, 4 gives 16, 5 gives 32 (24-bit colour in the low bits), 6 gives 16 and 7 gives 16 (12-bit colour in the low bits). Each accepted word yields exactly 32/bpp pixels, and then `pix_valid` falls unless another word was accepted.
- R2: `line_bytes` is cols>>3 for code 0, cols>>2 for code 1, cols>>1 for code 2, and cols for code 3. It is cols<<2 for code 5 and cols<<1 for codes 4, 6 and 7.
- R3: With `big_byte` and `big_pix` both clear, pixel k of a word comes from bits [k*bpp +: bpp], so the lowest-order pixel comes first.
- R4: With `big_byte` set, pixel k comes from bits [32-(k+1)*bpp +: bpp], so the highest-order pixel comes first. `big_pix` is then ignored.
- R5: With `big_byte` clear and `big_pix` set, at depths below 8 bits the bytes are taken lowest byte first, and within each byte the highest-order pixel comes first. At 8 bits and above, `big_pix` has no effect.
- R6: At codes 0 to 3 the pixel value, zero-extended, is driven on `pal_idx`, and the output colour is `pal_colour` from the same cycle.
- R7: Colours are widened by a left shift with zero fill. In 5551 red is bits 4:0, green 9:5 and blue 14:10, and bit 15 is ignored. In 565 red is 4:0, green 10:5 and blue 15:11. In 444 red is 3:0, green 7:4 and blue 11:8. In 888 red is 7:0, green 15:8 and blue 23:16. Code 5 is 888, code 7 is 444, and on the base variant code 6 is 565.
- R8: On the base variant (`variant_ext`=0), code 4 follows `mux_sel`. 1 gives 5551. 3 gives 565 with red and blue always exchanged, whatever `swap_rb` is. 0 and 2 give 565 that honours `swap_rb`.
- R9: On the extended variant (`variant_ext`=1), code 4 is always 5551 and code 6 is always 565, and `mux_sel` has no effect.
- R10: `swap_rb` set exchanges bits 23:16 and 7:0 of every output pixel, including palette colours.
- R11: After reset `pix_valid` is low and `word_ready` is high. While `pix_valid` is high and `pix_ready` low, `pix_rgb` holds and `word_ready` is low. `word_ready` is high whenever no pixel is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| depth_code | input | 3 | Pixel depth code |
| variant_ext | input | 1 | Variant strap: 1 means fixed 16-bit formats, no mux |
| mux_sel | input | 2 | External 16-bit colour mux select (base variant) |
| swap_rb | input | 1 | Exchange red and blue |
| big_byte | input | 1 | Highest-order pixel of the word first |
| big_pix | input | 1 | Highest-order sub-byte pixel first within each byte |
| cols | input | COLS_W | Pixels per line |
| line_bytes | output | COLS_W+2 | Bytes per line |
| word_valid | input | 1 | Framebuffer word offered |
| word_ready | output | 1 | Word accepted this cycle |
| word_data | input | 32 | Framebuffer word |
| pix_valid | output | 1 | Pixel offered |
| pix_ready | input | 1 | Pixel accepted this cycle |
| pix_rgb | output | 24 | Pixel colour R,G,B |
| pal_idx | output | 8 | Palette index for indexed depths |
| pal_colour | input | 24 | Colour returned by the palette for `pal_idx` |

## Verification
The bench sweeps every depth code against both variants, all four mux values, all three ordering modes and both swap settings. For each combination it sends two words and checks every pixel against a model that computes bit offsets and channel fields arithmetically. The ordering modes tell apart lowest-first, word-reversed and byte-wise sub-pixel reversal. The mux and variant sweep tells apart 5551 from 565 and the forced swap from the honoured swap. A palette that returns a colour derived from the index shows whether the index field was taken from the right bits. The ready pattern stalls every third cycle to exercise holding and the *reload* transition, and `line_bytes` is checked for each code at several column counts, including zero and the maximum.

// File: rtl/fb_unpack_pkg.sv
package fb_unpack_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        FMT_IDX,
        FMT_5551,
        FMT_565,
        FMT_444,
        FMT_888
    } fmt_e;

    typedef enum logic [0:0] {
        S_EMPTY,
        S_DRAIN
    } state_e;
endpackage

// File: rtl/fb_unpack_fmt.sv
module fb_unpack_fmt
    import fb_unpack_pkg::*;
(
    input  logic [2:0] depth_code,
    input  logic       variant_ext,
    input  logic [1:0] mux_sel,
    input  logic       swap_rb,
    output fmt_e       fmt,
    output logic [2:0] lg_w,
    output logic       swap_eff
);
    always_comb begin
        fmt      = FMT_IDX;
        lg_w     = 3'd0;
        swap_eff = swap_rb;
        unique case (depth_code)
            3'd0: begin fmt = FMT_IDX; lg_w = 3'd0; end
            3'd1: begin fmt = FMT_IDX; lg_w = 3'd1; end
            3'd2: begin fmt = FMT_IDX; lg_w = 3'd2; end
            3'd3: begin fmt = FMT_IDX; lg_w = 3'd3; end
            3'd4: begin
                lg_w = 3'd4;
                if (variant_ext) begin
                    fmt = FMT_5551;
                end else begin
                    unique case (mux_sel)
                        2'd1:    fmt = FMT_5551;
                        2'd3: begin fmt = FMT_565; swap_eff = 1'b1; end
                        default: fmt = FMT_565;
                    endcase
                end
            end
            3'd5: begin fmt = FMT_888; lg_w = 3'd5; end
            3'd6: begin fmt = FMT_565; lg_w = 3'd4; end
            default: begin fmt = FMT_444; lg_w = 3'd4; end
        endcase
    end
endmodule

// File: rtl/fb_unpack_sel.sv
module fb_unpack_sel
    import fb_unpack_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [4:0]        slot,
    input  logic [2:0]        lg_w,
    input  logic              big_byte,
    input  logic              big_pix,
    output logic [WORD_W-1:0] field
);
    logic [5:0]        w6;
    logic [4:0]        base_off;
    logic [4:0]        flip_word;
    logic [4:0]        flip_byte;
    logic [4:0]        off;
    logic [WORD_W-1:0] mask;

    always_comb begin
        w6        = 6'd1 << lg_w;
        base_off  = 5'(slot << lg_w);
        flip_word = 5'(6'd32 - w6);
        flip_byte = 5'(6'd8 - w6);
        if (big_byte)
            off = base_off ^ flip_word;
        else if (big_pix && (lg_w < 3'd3))
            off = base_off ^ flip_byte;
        else
            off = base_off;
        mask  = (lg_w == 3'd5) ? '1 : ((32'd1 << w6) - 32'd1);
        field = (word >> off) & mask;
    end
endmodule

// File: rtl/fb_unpack_color.sv
module fb_unpack_color
    import fb_unpack_pkg::*;
(
    input  logic [WORD_W-1:0] raw,
    input  fmt_e              fmt,
    input  logic              swap,
    input  logic [23:0]       pal_colour,
    output logic [7:0]        pal_idx,
    output logic [23:0]       rgb
);
    logic [7:0]  r8;
    logic [7:0]  g8;
    logic [7:0]  b8;
    logic [23:0] plain;

    assign pal_idx = raw[7:0];

    always_comb begin
        unique case (fmt)
            FMT_IDX:  plain = pal_colour;
            FMT_5551: plain = {raw[4:0], 3'b0, raw[9:5], 3'b0, raw[14:10], 3'b0};
            FMT_565:  plain = {raw[4:0], 3'b0, raw[10:5], 2'b0, raw[15:11], 3'b0};
            FMT_444:  plain = {raw[3:0], 4'b0, raw[7:4], 4'b0, raw[11:8], 4'b0};
            default:  plain = {raw[7:0], raw[15:8], raw[23:16]};
        endcase
        r8  = plain[23:16];
        g8  = plain[15:8];
        b8  = plain[7:0];
        rgb = swap ? {b8, g8, r8} : {r8, g8, b8};
    end
endmodule

// File: rtl/fb_unpack.sv
module fb_unpack
    import fb_unpack_pkg::*;
#(
    parameter int COLS_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        depth_code,
    input  logic              variant_ext,
    input  logic [1:0]        mux_sel,
    input  logic              swap_rb,
    input  logic              big_byte,
    input  logic              big_pix,
    input  logic [COLS_W-1:0] cols,
    output logic [COLS_W+1:0] line_bytes,
    input  logic              word_valid,
    output logic              word_ready,
    input  logic [31:0]       word_data,
    output logic              pix_valid,
    input  logic              pix_ready,
    output logic [23:0]       pix_rgb,
    output logic [7:0]        pal_idx,
    input  logic [23:0]       pal_colour
);
    localparam int LB_W = COLS_W + 2;

    state_e            state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic [4:0]        slot_q;
    fmt_e              fmt;
    logic [2:0]        lg_w;
    logic              swap_eff;
    logic [WORD_W-1:0] field;
    logic              slot_last;
    logic              take;
    logic              give;
    logic [LB_W-1:0]   cols_x;

    fb_unpack_fmt u_fmt (
        .depth_code (depth_code),
        .variant_ext(variant_ext),
        .mux_sel    (mux_sel),
        .swap_rb    (swap_rb),
        .fmt        (fmt),
        .lg_w       (lg_w),
        .swap_eff   (swap_eff)
    );

    fb_unpack_sel u_sel (
        .word    (word_q),
        .slot    (slot_q),
        .lg_w    (lg_w),
        .big_byte(big_byte),
        .big_pix (big_pix),
        .field   (field)
    );

    fb_unpack_color u_color (
        .raw       (field),
        .fmt       (fmt),
        .swap      (swap_eff),
        .pal_colour(pal_colour),
        .pal_idx   (pal_idx),
        .rgb       (pix_rgb)
    );

    assign slot_last = (slot_q == (5'd31 >> lg_w));
    assign take      = word_valid && word_ready;
    assign give      = pix_valid && pix_ready;

    // next-state logic: load, reload, drain_done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_EMPTY: if (take) state_d = S_DRAIN;
            S_DRAIN: if (give && slot_last && !take) state_d = S_EMPTY;
            default: state_d = S_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_EMPTY;
        else        state_q <= state_d;
    end

    // held word and pixel slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            slot_q <= '0;
        end else if (take) begin
            word_q <= word_data;
            slot_q <= '0;
        end else if (give) begin
            slot_q <= slot_q + 5'd1;
        end
    end

    // handshake outputs
    always_comb begin
        pix_valid  = 1'b0;
        word_ready = 1'b0;
        unique case (state_q)
            S_EMPTY: word_ready = 1'b1;
            S_DRAIN: begin
                pix_valid  = 1'b1;
                word_ready = pix_ready && slot_last;
            end
            default: word_ready = 1'b0;
        endcase
    end

    // bytes per line
    assign cols_x = LB_W'(cols);
    always_comb begin
        unique case (depth_code)
            3'd0:    line_bytes = cols_x >> 3;
            3'd1:    line_bytes = cols_x >> 2;
            3'd2:    line_bytes = cols_x >> 1;
            3'd3:    line_bytes = cols_x;
            3'd5:    line_bytes = cols_x << 2;
            default: line_bytes = cols_x << 1;
        endcase
    end
endmodule

// File: rtl/fb_unpack_chk.sv
module fb_unpack_chk #(
    parameter int COLS_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        depth_code,
    input logic [COLS_W-1:0] cols,
    input logic [COLS_W+1:0] line_bytes,
    input logic              word_valid,
    input logic              word_ready,
    input logic              pix_valid,
    input logic              pix_ready,
    input logic [23:0]       pix_rgb,
    input logic [7:0]        pal_idx
);
    // R11: a stalled pixel holds its colour
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && !pix_ready |=> pix_valid && $stable(pix_rgb));

    // R11: no new word while a pixel is stalled
    p_no_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && !pix_ready |-> !word_ready);

    // R11: nothing pending means ready for a word
    p_idle_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> word_ready);

    // R1: an accepted word produces a pixel next cycle
    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && word_ready |=> pix_valid);

    // R6: at one bit per pixel the index is 0 or 1
    p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && depth_code == 3'd0 |-> pal_idx[7:1] == 7'd0);

    // R2: eight-bit depth uses one byte per column
    p_bytes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        depth_code == 3'd3 |-> line_bytes == (COLS_W+2)'(cols));
endmodule

bind fb_unpack fb_unpack_chk #(.COLS_W(COLS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .depth_code(depth_code),
    .cols      (cols),
    .line_bytes(line_bytes),
    .word_valid(word_valid),
    .word_ready(word_ready),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .pix_rgb   (pix_rgb),
    .pal_idx   (pal_idx)
);

// File: tb/fb_unpack_bench.sv
module fb_unpack_bench;
    localparam int PERIOD = 10;
    localparam int COLS_W = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        depth_code = '0;
    logic              variant_ext = 1'b0;
    logic [1:0]        mux_sel = '0;
    logic              swap_rb = 1'b0;
    logic              big_byte = 1'b0;
    logic              big_pix = 1'b0;
    logic [COLS_W-1:0] cols = '0;
    logic [COLS_W+1:0] line_bytes;
    logic              word_valid = 1'b0;
    logic              word_ready;
    logic [31:0]       word_data = '0;
    logic              pix_valid;
    logic              pix_ready = 1'b0;
    logic [23:0]       pix_rgb;
    logic [7:0]        pal_idx;
    logic [23:0]       pal_colour;

    int checks = 0;
    int fails  = 0;
    int tick   = 0;
    logic [31:0] words [2];

    always #(PERIOD/2) clk = ~clk;

    assign pal_colour = {pal_idx, ~pal_idx, pal_idx ^ 8'h5A};

    fb_unpack #(.COLS_W(COLS_W)) u_fb_unpack (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int bpp();
        case (depth_code)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd5: return 32;
            default: return 16;
        endcase
    endfunction

    // expected colour of pixel k of word w (R3..R10)
    function automatic logic [23:0] expect_pix(input logic [31:0] w, input int k);
        int wd = bpp();
        int off, p, fm;
        logic [31:0] v, m;
        logic [7:0] r, g, b;
        bit sw = swap_rb;
        if (big_byte) off = 32 - (k + 1) * wd;
        else if (big_pix && wd < 8) begin
            p   = 8 / wd;
            off = (k / p) * 8 + (p - 1 - (k % p)) * wd;
        end else off = k * wd;
        m = (wd == 32) ? 32'hFFFF_FFFF : ((32'd1 << wd) - 1);
        v = (w >> off) & m;
        // 0 idx, 1 5551, 2 565, 3 444, 4 888
        if (depth_code < 3'd4) fm = 0;
        else if (depth_code == 3'd5) fm = 4;
        else if (depth_code == 3'd7) fm = 3;
        else if (depth_code == 3'd6) fm = 2;
        else if (variant_ext) fm = 1;
        else if (mux_sel == 2'd1) fm = 1;
        else begin
            fm = 2;
            if (mux_sel == 2'd3) sw = 1'b1;
        end
        case (fm)
            0: begin r = v[7:0]; g = ~v[7:0]; b = v[7:0] ^ 8'h5A; end
            1: begin r = {v[4:0], 3'b0}; g = {v[9:5], 3'b0}; b = {v[14:10], 3'b0}; end
            2: begin r = {v[4:0], 3'b0}; g = {v[10:5], 2'b0}; b = {v[15:11], 3'b0}; end
            3: begin r = {v[3:0], 4'b0}; g = {v[7:4], 4'b0}; b = {v[11:8], 4'b0}; end
            default: begin r = v[7:0]; g = v[15:8]; b = v[23:16]; end
        endcase
        return sw ? {b, g, r} : {r, g, b};
    endfunction

    function automatic string tag_of();
        if (big_byte) return "R4";
        if (big_pix && depth_code < 3'd3) return "R5";
        if (depth_code < 3'd4) return "R6";
        if (variant_ext && (depth_code == 3'd4 || depth_code == 3'd6)) return "R9";
        if (!variant_ext && depth_code == 3'd4) return "R8";
        if (swap_rb) return "R10";
        if (depth_code == 3'd5) return "R3";
        return "R7";
    endfunction

    task automatic run_cfg(input int seed);
        int total = 2 * (32 / bpp());
        words[0] = 32'hA5C3_1E69 ^ (seed * 32'h9E37_79B9);
        words[1] = {words[0][12:0], words[0][31:13]} ^ 32'h0F0F_3C3C;
        fork
            begin
                @(negedge clk);
                for (int i = 0; i < 2; i++) begin
                    bit hs = 1'b0;
                    word_valid = 1'b1;
                    word_data  = words[i];
                    while (!hs) begin
                        #1 hs = word_ready;
                        @(negedge clk);
                    end
                end
                word_valid = 1'b0;
            end
            begin
                int got = 0;
                @(negedge clk);
                while (got < total) begin
                    pix_ready = (tick % 3) != 1;
                    tick++;
                    #1;
                    if (pix_valid && !pix_ready)
                        check(!word_ready, "R11 stall", {31'b0, word_ready}, 32'd0);
                    if (pix_valid && pix_ready) begin
                        logic [23:0] e;
                        e = expect_pix(words[got / (total / 2)], got % (total / 2));
                        check(pix_rgb == e, tag_of(), {8'b0, pix_rgb}, {8'b0, e});
                        got++;
                    end
                    @(negedge clk);
                end
                pix_ready = 1'b0;
            end
        join
        @(negedge clk);
        #1 check(!pix_valid, "R1 pixel count", {31'b0, pix_valid}, 32'd0);
    endtask

    initial begin
        #(PERIOD * 190000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int seed = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!pix_valid, "R11 reset valid", {31'b0, pix_valid}, 32'd0);
        check(word_ready, "R11 reset ready", {31'b0, word_ready}, 32'd1);

        // R2: bytes per line for each code
        for (int d = 0; d < 8; d++) begin
            for (int c = 0; c < 4; c++) begin
                int cv, e;
                cv = (c == 0) ? 0 : (c == 1) ? 8 : (c == 2) ? 640 : 2047;
                depth_code = 3'(d);
                cols = COLS_W'(cv);
                #1;
                case (d)
                    0: e = cv / 8;
                    1: e = cv / 4;
                    2: e = cv / 2;
                    3: e = cv;
                    5: e = cv * 4;
                    default: e = cv * 2;
                endcase
                check(int'(line_bytes) == e, "R2", 32'(line_bytes), 32'(e));
            end
        end

        // R1, R3..R10: full configuration sweep
        for (int d = 0; d < 8; d++)
            for (int v = 0; v < 2; v++)
                for (int m = 0; m < 4; m++)
                    for (int o = 0; o < 3; o++)
                        for (int s = 0; s < 2; s++) begin
                            depth_code  = 3'(d);
                            variant_ext = v[0];
                            mux_sel     = 2'(m);
                            big_byte    = (o == 1);
                            big_pix     = (o == 2) || (o == 1 && s == 1);
                            swap_rb     = s[0];
                            seed++;
                            run_cfg(seed);
                        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule